// File: doc/BRIEF.md
# Lines-per-Field Serial Encoder

This block measures the vertical size of a video field by counting horizontal sync pulses, then sends that measurement to a receiver as a serial word on one data pin. Horizontal and vertical sync arrive as active-low levels that are already synchronous to the system clock. A falling level on either input is the leading edge of that sync. The block detects these edges by comparing each input with its value on the previous clock.

Horizontal pulses that start while vertical sync is low are not counted. A field therefore reports about three lines fewer than its true total. At each vertical sync leading edge, the count of the field that just ended is copied into a shift register and the counter starts again from zero. The word then leaves MSB first, one bit per horizontal sync leading edge, over eleven consecutive edges beginning with the third one after vertical sync. A receiver can use horizontal sync as the bit clock and sample the data at mid-line. For interlaced material the two fields report values one apart.

Top module: `lpf_encoder`

## Requirements
- R1: After reset `vf_data` is 0, and it stays unchanged through any horizontal pulses that come before the first vertical sync leading edge.
- R2: A horizontal sync leading edge seen while `vsync_n` is 1 adds one to the field count.
- R3: A horizontal sync leading edge seen while `vsync_n` is 0 leaves the field count unchanged.
- R4: At each vertical sync leading edge, the current count becomes the word to send and the count restarts at 0.
- R5: The first bit of the word appears on the third horizontal sync leading edge after the vertical sync leading edge. Edges are numbered from 1, every edge counts toward this number, and an edge detected in the same cycle as the vertical edge is not counted.
- R6: The word is CNT_W = 11 bits and is sent MSB first on edges 3 through 13, one bit per edge. For example, 560 is sent as 0,1,0,0,0,1,1,0,0,0,0.
- R7: `vf_data` updates on the first rising clock edge that samples `hsync_n` low after it was high, and at no other time.
- R8: The field count saturates at 2047 and stays there when more pulses arrive.
- R9: On horizontal edges outside the 3 to 13 window, `vf_data` keeps its previous level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_n | input | 1 | Horizontal sync, active low, synchronous to clk |
| vsync_n | input | 1 | Vertical sync, active low, synchronous to clk |
| vf_data | output | 1 | Serial lines-per-field data, MSB first |

## Verification
On every cycle the assertions check four things: the data pin moves only after a detected horizontal edge, the count clears on a vertical edge, pulses inside vertical sync leave the count alone, and the count either steps by one or holds at its ceiling. Only the bench scenarios can show the rest. They cover the full serial framing (the third-edge offset, MSB-first order, the bits matching the count of the previous field) and the holding of the data level outside the window. The fields vary in length, in the number of pulses inside vertical sync, and include one that reaches saturation.

// File: rtl/lpf_encoder.sv
module lpf_encoder #(
  parameter int CNT_W      = 11,
  parameter int START_EDGE = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_n,
  input  logic vsync_n,
  output logic vf_data
);
  localparam int LAST = START_EDGE + CNT_W - 1;
  localparam int PW   = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic hs_q, vs_q;
  logic [CNT_W-1:0] cnt, sh;
  logic [PW-1:0] pos, pos_nx;

  wire hs_edge = hs_q & ~hsync_n;
  wire vs_edge = vs_q & ~vsync_n;
  assign pos_nx = pos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      hs_q <= hsync_n;
      vs_q <= vsync_n;
    end
  end

  // field counter: saturating, frozen inside vertical sync
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (vs_edge)
      cnt <= '0;
    else if (hs_edge && vsync_n && cnt != CMAX)
      cnt <= cnt + 1'b1;
  end

  // serializer: idle (pos == LAST) until the first vertical edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= PW'(LAST);
      sh      <= '0;
      vf_data <= 1'b0;
    end else if (vs_edge) begin
      pos <= '0;
      sh  <= cnt;
    end else if (hs_edge && pos < PW'(LAST)) begin
      pos <= pos_nx;
      if (pos_nx >= PW'(START_EDGE)) begin
        vf_data <= sh[CNT_W-1];
        sh      <= {sh[CNT_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/lpf_encoder_chk.sv
module lpf_encoder_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vsync_n,
  input logic             hs_edge,
  input logic             vs_edge,
  input logic [CNT_W-1:0] cnt,
  input logic             vf_data
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  a_r7_data_moves_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vf_data) |-> $past(hs_edge));

  a_r4_count_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    vs_edge |=> cnt == '0);

  a_r3_frozen_in_vsync: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_n && !vs_edge) |=> $stable(cnt));

  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_edge && vsync_n && cnt != CMAX) |=> cnt == $past(cnt) + 1'b1);

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !vs_edge) |=> cnt == CMAX);
endmodule

bind lpf_encoder lpf_encoder_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .hs_edge(hs_edge),
  .vs_edge(vs_edge), .cnt(cnt), .vf_data(vf_data)
);

// File: tb/lpf_encoder_tb.sv
module lpf_encoder_tb_top;
  localparam int W = 11;
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, hsync_n = 1'b1, vsync_n = 1'b1;
  logic vf_data;
  int vectors = 0, errors = 0;
  bit done = 0;

  int cur_cnt = 0, k = 99;
  logic [W-1:0] word = '0;
  logic exp_d = 1'b0;

  always #5 clk = ~clk;

  lpf_encoder dut_i (.clk(clk), .rst_n(rst_n), .hsync_n(hsync_n),
                     .vsync_n(vsync_n), .vf_data(vf_data));

  task automatic check(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: vf_data=%0b expected %0b (edge %0d)", req, act, exp, k);
    end
  endtask

  // one horizontal pulse: low for one cycle, high for two
  task automatic hpulse();
    string req;
    @(negedge clk) hsync_n = 1'b0;
    check(vf_data, exp_d, "R7");           // not yet sampled by the clock
    if (k < 99) k++;
    if (vsync_n) cur_cnt = (cur_cnt < CMAX) ? cur_cnt + 1 : CMAX;  // R2, R3, R8
    if (k == 99) req = "R1";
    else if (k >= 3 && k <= 13) begin
      exp_d = word[13-k];
      req = (k == 3) ? "R5" : "R6";
    end else req = "R9";
    @(negedge clk);
    check(vf_data, exp_d, req);
    hsync_n = 1'b1;
    @(negedge clk);
  endtask

  // vertical sync leading edge latches the count (R4)
  task automatic vfall();
    @(negedge clk) vsync_n = 1'b0;
    word = W'(cur_cnt);
    cur_cnt = 0;
    k = 0;
    @(negedge clk);
  endtask

  task automatic field(input int lines, input int in_vs);
    vfall();
    for (int i = 0; i < in_vs; i++) hpulse();
    @(negedge clk) vsync_n = 1'b1;
    for (int i = in_vs; i < lines; i++) hpulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(vf_data, 1'b0, "R1");
    for (int i = 0; i < 5; i++) hpulse();  // before any vertical sync (R1)
    for (int f = 0; f < 14; f++) begin
      int v, l;
      v = f % 4;
      if (f == 12) l = CMAX + v;           // exactly at the ceiling
      else if (f == 13) l = 2100;          // beyond it: saturation (R8)
      else l = 6 + f * f * 11 + (f % 2);   // alternating parity, interlace-like
      field(l, v);
    end
    field(15, 3);                          // flush the last word
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete (R1 onward), actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule